// File: doc/BRIEF.md
# Six-Channel DMA Request Arbiter

This block is the front end of a six-channel DMA engine. It collects transfer requests from four off-chip requesters and two on-chip peripherals. It gains the bus from the CPU with a simple hold request and grant pair, then picks one armed requester per transfer and acknowledges it. It also counts each channel's transfers down from a programmed value. Off-chip channels get an active-low acknowledge. On-chip channels get an active-high one. Address generation and the data path sit elsewhere.

The block owns one shared pin split into three signals: pad value in, drive value out and output enable. It has two modes. In terminal-count mode the block drives the pin, and it pulses the pin high for one clock during the last transfer of any channel. In end-of-process mode the block leaves the pin undriven. A requester can then pull the pin low during a transfer to abort its channel. A channel that runs out of count or is aborted disarms itself and raises its done flag. Writing a new count re-arms the channel.

Each granted transfer takes one clock. Between transfers there is always one re-arbitration clock, so a channel gets at most one transfer every two clocks. Both modes of the shared pin sample it as a synchronous signal.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, hold_req is 0, every ext_ack_n bit is 1, int_ack is 0, chan_done is 0, and every channel is disarmed, so its request is ignored until a count is written.
- R2: hold_req rises on the clock edge after any armed channel presents a request. No acknowledge is given until hold_gnt has been seen high while hold_req is high.
- R3: In each transfer clock exactly one channel is acknowledged. Channels 0..3 use ext_ack_n[i] driven to 0. Channels 4..5 use int_ack[i-4] driven to 1.
- R4: With cfg_rotate = 0, the armed requesting channel with the lowest index wins.
- R5: With cfg_rotate = 1, the search starts at the index one above the previous winner and wraps from 5 to 0. The last winner therefore has the lowest priority.
- R6: In terminal-count mode (cfg_eop_mode = 0), tceop_oe is 1. tceop_out is 1 for exactly the one transfer clock in which the acknowledged channel's remaining count is 1. It is 0 at all other times.
- R7: After the final counted transfer, the channel's chan_done bit is 1 from the next clock on. The channel is disarmed, so its requests no longer raise hold_req or win.
- R8: In end-of-process mode (cfg_eop_mode = 1), tceop_oe and tceop_out are 0. A 0 on tceop_in during a transfer clock ends that channel: its chan_done bit sets on the next clock and the channel is disarmed.
- R9: In terminal-count mode, tceop_in has no effect on any channel.
- R10: After a transfer clock with no other armed channel still requesting, hold_req falls on the next clock. hold_req also falls if all requests are withdrawn while the grant is pending.
- R11: A write with cnt_wr_en = 1 loads cnt_wr_val into channel cnt_wr_ch, arms that channel and clears its chan_done bit. A value of 0 means 65536 transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rotate | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| cfg_eop_mode | input | 1 | 1 makes the shared pin an abort input, 0 makes it a terminal-count output |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_ch | input | 3 | Channel index for the count write |
| cnt_wr_val | input | 16 | Transfer count to load |
| ext_req | input | 4 | Off-chip requests, active high |
| int_req | input | 2 | On-chip peripheral requests, active high |
| ext_ack_n | output | 4 | Off-chip acknowledges, active low |
| int_ack | output | 2 | On-chip acknowledges, active high |
| hold_req | output | 1 | Bus hold request to the CPU |
| hold_gnt | input | 1 | Bus grant from the CPU |
| tceop_in | input | 1 | Value seen at the shared pin |
| tceop_out | output | 1 | Value driven on the shared pin |
| tceop_oe | output | 1 | Drive enable for the shared pin |
| chan_done | output | 6 | Per-channel flag for expired or aborted |

## Verification
Corrupted winner or pointer state shows up as the wrong acknowledge bit in the very next transfer clock, so every acknowledge pattern is compared cycle by cycle. A counter that is off by one moves the terminal-count pulse and the chan_done edge by one transfer, which appears two clocks later. Bad arming state appears as hold_req rising for a channel that is finished. It also appears as hold_req failing to rise after a count is written. Both show within one clock of the request.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } arb_state_e;

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic          rotate,
  input  logic [IW-1:0] last_idx,
  output logic [N-1:0]  win_oh,
  output logic [IW-1:0] win_idx,
  output logic          any
);

  logic [IW-1:0] base;

  always_comb begin
    if (!rotate) begin
      base = '0;
    end else if (last_idx == IW'(N - 1)) begin
      base = '0;
    end else begin
      base = last_idx + IW'(1);
    end
  end

  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      automatic int pos = (int'(base) + k) % N;
      if (!any && pend[pos]) begin
        any         = 1'b1;
        win_oh[pos] = 1'b1;
        win_idx     = IW'(pos);
      end
    end
  end

endmodule

// File: rtl/dma_chan_cnt.sv
module dma_chan_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             xfer,
  input  logic             abort,
  output logic             armed,
  output logic             done,
  output logic             last,
  output logic             fin
);

  logic [CNT_W-1:0] remain;

  assign last = (remain == CNT_W'(1));
  assign fin  = xfer && (last || abort);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      armed  <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      remain <= load_val;
      armed  <= 1'b1;
      done   <= 1'b0;
    end else if (xfer) begin
      remain <= remain - CNT_W'(1);
      if (last || abort) begin
        armed <= 1'b0;
        done  <= 1'b1;
      end
    end
  end

  // R7: a finished channel never stays armed
  p_done_disarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !armed);

  // R11: a count write arms the channel and clears its flag
  p_load_arms_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (armed && !done));

  // R7: the flag only rises after a finishing transfer
  p_done_after_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));

endmodule

// File: rtl/dma_tc_pin.sv
module dma_tc_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic eop_mode,
  input  logic xfer_active,
  input  logic win_last,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic abort
);

  assign pin_oe  = !eop_mode;
  assign pin_out = !eop_mode && xfer_active && win_last;
  assign abort   = eop_mode && xfer_active && !pin_in;

  // R6: the pulse is a single clock wide
  p_tc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |=> !pin_out);

  // R8: nothing is driven while the pin is an input
  p_eop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eop_mode |-> (!pin_out && !pin_oe));

  // R9: the pad value cannot abort in terminal-count mode
  p_no_abort_tc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_mode |-> !abort);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_CH  = 6,
  parameter int NUM_EXT = 4,
  parameter int CNT_W   = 16,
  localparam int NUM_INT = NUM_CH - NUM_EXT,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_rotate,
  input  logic               cfg_eop_mode,
  input  logic               cnt_wr_en,
  input  logic [CH_W-1:0]    cnt_wr_ch,
  input  logic [CNT_W-1:0]   cnt_wr_val,
  input  logic [NUM_EXT-1:0] ext_req,
  input  logic [NUM_INT-1:0] int_req,
  output logic [NUM_EXT-1:0] ext_ack_n,
  output logic [NUM_INT-1:0] int_ack,
  output logic               hold_req,
  input  logic               hold_gnt,
  input  logic               tceop_in,
  output logic               tceop_out,
  output logic               tceop_oe,
  output logic [NUM_CH-1:0]  chan_done
);

  import dma_arb_pkg::*;

  arb_state_e        st_q, st_d;
  logic [NUM_CH-1:0] req_all, armed, pend, rem;
  logic [NUM_CH-1:0] last_vec, fin_vec, ack_oh;
  logic [NUM_CH-1:0] pick_oh, win_oh_q;
  logic [CH_W-1:0]   pick_idx, last_win_q;
  logic              pick_any, xfer_active, win_last, abort;

  assign req_all     = {int_req, ext_req};
  assign pend        = req_all & armed;
  assign xfer_active = (st_q == ST_XFER);
  assign rem         = pend & ~fin_vec;
  assign win_last    = |(last_vec & win_oh_q);
  assign ack_oh      = xfer_active ? win_oh_q : '0;

  dma_prio_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
    .pend     (pend),
    .rotate   (cfg_rotate),
    .last_idx (last_win_q),
    .win_oh   (pick_oh),
    .win_idx  (pick_idx),
    .any      (pick_any)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr_en && (cnt_wr_ch == CH_W'(c))),
        .load_val (cnt_wr_val),
        .xfer     (ack_oh[c]),
        .abort    (abort),
        .armed    (armed[c]),
        .done     (chan_done[c]),
        .last     (last_vec[c]),
        .fin      (fin_vec[c])
      );
    end
  endgenerate

  dma_tc_pin u_pin (
    .clk         (clk),
    .rst_n       (rst_n),
    .eop_mode    (cfg_eop_mode),
    .xfer_active (xfer_active),
    .win_last    (win_last),
    .pin_in      (tceop_in),
    .pin_out     (tceop_out),
    .pin_oe      (tceop_oe),
    .abort       (abort)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (|pend) st_d = ST_REQ;
      ST_REQ: begin
        if (!(|pend))           st_d = ST_IDLE;
        else if (hold_gnt)      st_d = ST_XFER;
      end
      ST_XFER: st_d = (|rem) ? ST_REQ : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      win_oh_q   <= '0;
      last_win_q <= CH_W'(NUM_CH - 1);
    end else begin
      st_q <= st_d;
      if (st_q == ST_REQ && hold_gnt && pick_any) begin
        win_oh_q   <= pick_oh;
        last_win_q <= pick_idx;
      end
    end
  end

  assign hold_req  = (st_q != ST_IDLE);
  assign ext_ack_n = ~ack_oh[NUM_EXT-1:0];
  assign int_ack   = ack_oh[NUM_CH-1:NUM_EXT];

  // R3: never more than one acknowledge
  p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_ack, ~ext_ack_n}));

  // R2: an acknowledge follows a sampled grant
  p_ack_after_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|{int_ack, ~ext_ack_n}) |-> ($past(hold_gnt) && hold_req));

  // R4: the winner was an armed requester when picked
  p_win_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> (|($past(pend) & win_oh_q)));

  // R10: bus released when nothing is left to serve
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !(|rem)) |=> !hold_req);

  // R6: the terminal pulse only appears with an acknowledge
  p_tc_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tceop_out |-> (|{int_ack, ~ext_ack_n}));

endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rotate = 1'b0;
  logic        cfg_eop_mode = 1'b0;
  logic        cnt_wr_en = 1'b0;
  logic [2:0]  cnt_wr_ch = '0;
  logic [15:0] cnt_wr_val = '0;
  logic [3:0]  ext_req = '0;
  logic [1:0]  int_req = '0;
  logic [3:0]  ext_ack_n;
  logic [1:0]  int_ack;
  logic        hold_req;
  logic        hold_gnt = 1'b0;
  logic        tceop_in = 1'b1;
  logic        tceop_out;
  logic        tceop_oe;
  logic [5:0]  chan_done;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_req_arbiter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rotate   (cfg_rotate),
    .cfg_eop_mode (cfg_eop_mode),
    .cnt_wr_en    (cnt_wr_en),
    .cnt_wr_ch    (cnt_wr_ch),
    .cnt_wr_val   (cnt_wr_val),
    .ext_req      (ext_req),
    .int_req      (int_req),
    .ext_ack_n    (ext_ack_n),
    .int_ack      (int_ack),
    .hold_req     (hold_req),
    .hold_gnt     (hold_gnt),
    .tceop_in     (tceop_in),
    .tceop_out    (tceop_out),
    .tceop_oe     (tceop_oe),
    .chan_done    (chan_done)
  );

  // rot, ext_req, int_req, gnt, pin | hold, ext_ack_n, int_ack, tc, done
  typedef struct packed {
    logic       rot;
    logic [3:0] ereq;
    logic [1:0] ireq;
    logic       gnt;
    logic       pin;
    logic       x_hold;
    logic [3:0] x_ackn;
    logic [1:0] x_iack;
    logic       x_tc;
    logic [5:0] x_done;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'b0111, 2'b00, 1'b0, 1'b1, 1'b1, 4'b1111, 2'b00, 1'b0, 6'b000000},
    '{1'b0, 4'b0111, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1110, 2'b00, 1'b0, 6'b000000},
    '{1'b0, 4'b0111, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1111, 2'b00, 1'b0, 6'b000000},
    '{1'b0, 4'b0111, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1110, 2'b00, 1'b1, 6'b000000},
    '{1'b0, 4'b0111, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1111, 2'b00, 1'b0, 6'b000001},
    '{1'b0, 4'b0111, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1101, 2'b00, 1'b0, 6'b000001},
    '{1'b0, 4'b0111, 2'b00, 1'b1, 1'b0, 1'b1, 4'b1111, 2'b00, 1'b0, 6'b000001},
    '{1'b1, 4'b0111, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1011, 2'b00, 1'b1, 6'b000001},
    '{1'b1, 4'b0111, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1111, 2'b00, 1'b0, 6'b000101},
    '{1'b1, 4'b0111, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1101, 2'b00, 1'b0, 6'b000101},
    '{1'b1, 4'b0000, 2'b00, 1'b1, 1'b1, 1'b0, 4'b1111, 2'b00, 1'b0, 6'b000101},
    '{1'b1, 4'b0001, 2'b00, 1'b1, 1'b1, 1'b0, 4'b1111, 2'b00, 1'b0, 6'b000101}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic program_count(input logic [2:0] ch, input logic [15:0] val);
    cnt_wr_en  = 1'b1;
    cnt_wr_ch  = ch;
    cnt_wr_val = val;
    step();
    cnt_wr_en  = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 hold_req", 32'(hold_req), 32'd0);
    check("R1 ext_ack_n", 32'(ext_ack_n), 32'hf);
    check("R1 int_ack", 32'(int_ack), 32'd0);
    check("R1 chan_done", 32'(chan_done), 32'd0);
    rst_n = 1'b1;
    step();
    // R1: unprogrammed channels ignore requests
    ext_req = 4'b1111;
    int_req = 2'b11;
    step();
    check("R1 unarmed ignored", 32'(hold_req), 32'd0);
    ext_req = '0;
    int_req = '0;

    // R11: load counts ch0=2 ch1=3 ch2=1
    program_count(3'd0, 16'd2);
    program_count(3'd1, 16'd3);
    program_count(3'd2, 16'd1);

    // table walk: R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      cfg_rotate = VEC[i].rot;
      ext_req    = VEC[i].ereq;
      int_req    = VEC[i].ireq;
      hold_gnt   = VEC[i].gnt;
      tceop_in   = VEC[i].pin;
      step();
      check($sformatf("R2/R10 hold row %0d", i), 32'(hold_req), 32'(VEC[i].x_hold));
      check($sformatf("R3/R4/R5 ackn row %0d", i), 32'(ext_ack_n), 32'(VEC[i].x_ackn));
      check($sformatf("R3 iack row %0d", i), 32'(int_ack), 32'(VEC[i].x_iack));
      check($sformatf("R6 tc row %0d", i), 32'(tceop_out), 32'(VEC[i].x_tc));
      check($sformatf("R6 oe row %0d", i), 32'(tceop_oe), 32'd1);
      check($sformatf("R7/R9 done row %0d", i), 32'(chan_done), 32'(VEC[i].x_done));
    end
    ext_req = '0;
    tceop_in = 1'b1;
    cfg_rotate = 1'b0;

    // R11: reprogramming clears the flag
    program_count(3'd4, 16'd1);
    program_count(3'd0, 16'd1);
    check("R11 done cleared", 32'(chan_done), 32'b000100);

    // R2: internal channel waits for grant
    hold_gnt = 1'b0;
    int_req  = 2'b01;
    step();
    check("R2 hold raised", 32'(hold_req), 32'd1);
    step();
    step();
    check("R2 no ack without gnt", 32'({int_ack, ~ext_ack_n}), 32'd0);
    hold_gnt = 1'b1;
    step();
    check("R3 internal ack", 32'(int_ack), 32'b01);
    check("R3 no ext ack", 32'(ext_ack_n), 32'hf);
    check("R6 internal tc", 32'(tceop_out), 32'd1);
    step();
    check("R7 internal done", 32'(chan_done), 32'b010100);
    check("R10 internal release", 32'(hold_req), 32'd0);
    int_req = '0;

    // R8: end-of-process abort on ch3
    cfg_eop_mode = 1'b1;
    program_count(3'd3, 16'd5);
    ext_req = 4'b1000;
    step();
    check("R8 hold", 32'(hold_req), 32'd1);
    step();
    check("R8 ack ch3", 32'(ext_ack_n), 32'b0111);
    check("R8 oe low", 32'(tceop_oe), 32'd0);
    check("R8 out low", 32'(tceop_out), 32'd0);
    tceop_in = 1'b0;
    step();
    tceop_in = 1'b1;
    check("R8 abort done", 32'(chan_done), 32'b011100);
    check("R8 abort release", 32'(hold_req), 32'd0);
    step();
    check("R8 aborted ignored", 32'(hold_req), 32'd0);
    ext_req = '0;
    cfg_eop_mode = 1'b0;

    // R10: withdraw while grant pending
    hold_gnt = 1'b0;
    program_count(3'd5, 16'd3);
    int_req = 2'b10;
    step();
    check("R10 pending hold", 32'(hold_req), 32'd1);
    int_req = 2'b00;
    step();
    check("R10 withdraw drop", 32'(hold_req), 32'd0);
    check("R10 no ack", 32'(int_ack), 32'd0);

    finish_run();
  end

endmodule